// File: doc/BRIEF.md
# Serial Character Transmitter with Idle Guard and Break Control

This block turns parallel characters into an asynchronous serial stream. Software (or a neighbouring block) writes one character at a time into a single holding slot. At a baud-tick boundary, the character moves into a shift register and leaves on the line in this order: a low start bit, then the data bits, then an optional parity or address bit, then one or two high stop bits. Each bit lasts exactly one baud-tick period. The baud divider sits outside the block and supplies `baud_tick` as a one-cycle strobe.

The frame is configured live through static inputs:

- data width of five to eight bits, or a forced nine-bit width;
- bit order, least or most significant bit first;
- parity: even, odd, forced 0, forced 1, none, or a multi-drop address flag;
- one or two stop bits;
- an idle guard of a programmable number of bit periods after every character.

One-cycle command pulses do the rest:

- enable or disable the transmitter;
- reset the transmitter;
- mark the next written character as an address;
- start or stop a line break.

A requested break waits behind any character that is already held, then keeps the line low until it is stopped.

Top module: `sertx_guard`

## Requirements
- R1: After reset the line is high, `tx_ready` and `tx_empty` are 1, and the transmitter is disabled.
- R2: A frame is a 0 start bit, the data bits, the optional parity bit, then stop bits at 1. It starts only on a baud tick, and each bit is held for exactly one baud-tick period.
- R3: With `cfg_nine`=0, the data width is 5 + `cfg_len` (codes 0..3 give 5..8 bits), and data bits above that width are ignored. With `cfg_nine`=1, all nine bits `wr_data[8:0]` are sent.
- R4: With `cfg_msb_first`=1, the top bit of the selected width goes first; otherwise bit 0 goes first.
- R5: The `cfg_parity` codes are:
  - 0: even, so the data plus parity bit hold an even number of ones;
  - 1: odd;
  - 2: parity bit forced to 0;
  - 3: parity bit forced to 1;
  - 4, 6 and 7: no parity bit;
  - 5: multi-drop, where the parity position carries the address flag.
- R6: After a `cmd_send_addr` pulse, the next accepted write is sent with an address flag of 1. Later writes carry 0.
- R7: `cfg_two_stop`=1 sends two stop bits; otherwise one stop bit is sent.
- R8: After the last stop bit, the line stays high for exactly `cfg_guard` bit periods before the next start bit. With a guard of 0, a held character starts right behind the stop bit.
- R9: After `cmd_brk_start`, the line goes low at the first character boundary at which no enabled character is held. It stays low until `cmd_brk_stop`, after which the line is high in the next cycle. `tx_ready` is 0 from the request until the stop.
- R10: `tx_empty` is 1 exactly when the holding slot is free, and `tx_ready` = `tx_empty` with no break requested. A write while the slot is full is ignored.
- R11: Enable and disable take effect only at character boundaries. A character in flight always completes, and a held character does not start while the transmitter is disabled.
- R12: `cmd_tx_reset` aborts the character in flight, so the line is high in the next cycle. It also empties the holding slot and cancels any break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit period |
| cfg_len | input | 2 | Data width code, 5 + value bits |
| cfg_nine | input | 1 | Force nine data bits |
| cfg_msb_first | input | 1 | Send most significant bit first |
| cfg_parity | input | 3 | Parity / address mode code |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_guard | input | GUARD_W | Idle bit periods after each character |
| cmd_tx_on | input | 1 | Enable transmitter (pulse) |
| cmd_tx_off | input | 1 | Disable transmitter (pulse) |
| cmd_tx_reset | input | 1 | Abort and flush transmitter (pulse) |
| cmd_send_addr | input | 1 | Next write carries address flag (pulse) |
| cmd_brk_start | input | 1 | Request break (pulse) |
| cmd_brk_stop | input | 1 | End break (pulse) |
| wr_en | input | 1 | Write strobe for the holding slot |
| wr_data | input | 9 | Character to write |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Slot free and no break requested |
| tx_empty | output | 1 | Slot free |

## Verification
The properties assume the following about the inputs:

- `baud_tick` is a single-cycle strobe.
- Command pulses last one cycle.
- A break-stop pulse is the only event, besides a tick or a transmitter reset, that may change the line.

The bench raises the tick from a free-running generator on one cycle in eight, and it drives every command as a single-cycle pulse at the falling edge. It writes a character only when it means to test an ignored write, or after `tx_empty` has risen. It changes configuration only while the line is idle, so that every frame is built from one consistent setting.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  localparam logic [2:0] PAR_EVEN  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_SPACE = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_MDROP = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_GUARD, ST_BREAK} tx_st_e;

  function automatic logic [LEN_W-1:0] char_bits(input logic [1:0] len_code, input logic nine);
    return nine ? LEN_W'(DATA_W) : LEN_W'(5) + LEN_W'(len_code);
  endfunction

  function automatic logic has_parity(input logic [2:0] par);
    return (par <= PAR_MARK) || (par == PAR_MDROP);
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input logic [LEN_W-1:0] nb,
                                                 input logic [2:0] par, input logic two);
    return LEN_W'(1) + nb + LEN_W'(has_parity(par)) + (two ? LEN_W'(2) : LEN_W'(1));
  endfunction

  // Frame packed with the first bit to leave the line at index 0; stops are the '1 fill.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d,
      input logic [LEN_W-1:0] nb, input logic msb, input logic [2:0] par, input logic adr);
    logic [FRAME_W-1:0] f;
    logic [LEN_W-1:0]   pos;
    logic               ones;
    logic               pb;
    f    = '1;
    f[0] = 1'b0;
    pos  = LEN_W'(1);
    ones = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (LEN_W'(i) < nb) begin
        f[pos] = msb ? d[nb - LEN_W'(1) - LEN_W'(i)] : d[i];
        ones   = ones ^ d[i];
        pos    = pos + LEN_W'(1);
      end
    end
    case (par)
      PAR_EVEN:  pb = ones;
      PAR_ODD:   pb = ~ones;
      PAR_SPACE: pb = 1'b0;
      PAR_MARK:  pb = 1'b1;
      PAR_MDROP: pb = adr;
      default:   pb = 1'b1;
    endcase
    if (has_parity(par)) f[pos] = pb;
    return f;
  endfunction
endpackage

// File: rtl/sertx_hold.sv
`timescale 1ns/1ps
module sertx_hold
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_addr,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              addr
);
  logic accept;
  assign accept = wr_en && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
      addr <= 1'b0;
    end else if (clear || load) begin
      full <= 1'b0;
    end else if (accept) begin
      full <= 1'b1;
      data <= wr_data;
      addr <= wr_addr;
    end
  end

  // R10: a write into an occupied slot leaves its content untouched
  p_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !clear && !load) |=> (full && $stable(data) && $stable(addr)));
endmodule

// File: rtl/sertx_shift.sv
`timescale 1ns/1ps
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               abort,
  input  logic               brk_req,
  input  logic               brk_stop,
  input  logic               can_load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   flen,
  input  logic [GUARD_W-1:0] guard,
  output logic               txd,
  output logic               load_ev,
  output logic               brk_enter
);
  tx_st_e             st;
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   bits_left;
  logic [GUARD_W-1:0] gcnt;
  logic               last_bit;
  logic               bnd;

  assign last_bit  = (bits_left == '0);
  assign bnd       = baud_tick && ((st == ST_IDLE) ||
                                   (st == ST_DATA && last_bit && guard == '0) ||
                                   (st == ST_GUARD && gcnt == GUARD_W'(1)));
  assign load_ev   = bnd && can_load;
  assign brk_enter = bnd && !can_load && brk_req && !brk_stop;
  assign txd       = (st == ST_DATA) ? shreg[0] : (st != ST_BREAK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      shreg     <= '1;
      bits_left <= '0;
      gcnt      <= '0;
    end else if (abort) begin
      st <= ST_IDLE;
    end else if (bnd) begin
      if (load_ev) begin
        shreg     <= frame;
        bits_left <= flen - LEN_W'(1);
        st        <= ST_DATA;
      end else if (brk_enter) begin
        st <= ST_BREAK;
      end else begin
        st <= ST_IDLE;
      end
    end else if (st == ST_BREAK) begin
      if (brk_stop) st <= ST_IDLE;
    end else if (baud_tick) begin
      if (st == ST_DATA) begin
        if (last_bit) begin
          st   <= ST_GUARD;
          gcnt <= guard;
        end else begin
          shreg     <= {1'b1, shreg[FRAME_W-1:1]};
          bits_left <= bits_left - LEN_W'(1);
        end
      end else if (st == ST_GUARD) begin
        gcnt <= gcnt - GUARD_W'(1);
      end
    end
  end

  // R2: the line moves only on a tick (or on abort / break release)
  p_bit_paced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !abort && !brk_stop) |=> $stable(txd));
  // R2: a character always opens with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !abort) |=> !txd);
  // R12: abort returns the line high at once
  p_abort_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> txd);
endmodule

// File: rtl/sertx_guard.sv
`timescale 1ns/1ps
module sertx_guard
  import sertx_pkg::*;
#(
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic [1:0]         cfg_len,
  input  logic               cfg_nine,
  input  logic               cfg_msb_first,
  input  logic [2:0]         cfg_parity,
  input  logic               cfg_two_stop,
  input  logic [GUARD_W-1:0] cfg_guard,
  input  logic               cmd_tx_on,
  input  logic               cmd_tx_off,
  input  logic               cmd_tx_reset,
  input  logic               cmd_send_addr,
  input  logic               cmd_brk_start,
  input  logic               cmd_brk_stop,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               txd,
  output logic               tx_ready,
  output logic               tx_empty
);
  logic               tx_en;
  logic               brk_req;
  logic               addr_pend;
  logic               hold_full;
  logic [DATA_W-1:0]  hold_data;
  logic               hold_addr;
  logic               load_ev;
  logic               brk_enter;
  logic               wr_accept;
  logic [LEN_W-1:0]   nbits;
  logic [LEN_W-1:0]   flen;
  logic [FRAME_W-1:0] frame;

  assign wr_accept = wr_en && !hold_full;
  assign nbits     = char_bits(cfg_len, cfg_nine);
  assign flen      = frame_len(nbits, cfg_parity, cfg_two_stop);
  assign frame     = build_frame(hold_data, nbits, cfg_msb_first, cfg_parity, hold_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en     <= 1'b0;
      brk_req   <= 1'b0;
      addr_pend <= 1'b0;
    end else begin
      if (cmd_tx_off)      tx_en <= 1'b0;
      else if (cmd_tx_on)  tx_en <= 1'b1;

      if (cmd_brk_stop || cmd_tx_reset) brk_req <= 1'b0;
      else if (cmd_brk_start)           brk_req <= 1'b1;

      if (cmd_tx_reset || wr_accept) addr_pend <= 1'b0;
      else if (cmd_send_addr)        addr_pend <= 1'b1;
    end
  end

  sertx_hold i_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cmd_tx_reset),
    .load    (load_ev),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_addr (addr_pend || cmd_send_addr),
    .full    (hold_full),
    .data    (hold_data),
    .addr    (hold_addr)
  );

  sertx_shift #(.GUARD_W(GUARD_W)) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .abort     (cmd_tx_reset),
    .brk_req   (brk_req),
    .brk_stop  (cmd_brk_stop),
    .can_load  (hold_full && tx_en),
    .frame     (frame),
    .flen      (flen),
    .guard     (cfg_guard),
    .txd       (txd),
    .load_ev   (load_ev),
    .brk_enter (brk_enter)
  );

  assign tx_empty = !hold_full;
  assign tx_ready = !hold_full && !brk_req;

  // R11: the shifter only pulls a character that is held while enabled
  p_load_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |-> (hold_full && tx_en));
  // R9: entering break drives the line low and keeps ready low
  p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_enter && !cmd_tx_reset) |=> (!txd && !tx_ready));
endmodule

// File: tb/test_sertx_guard.sv
`timescale 1ns/1ps
module test_sertx_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_nine = 1'b0;
  logic       cfg_msb_first = 1'b0;
  logic [2:0] cfg_parity = 3'd4;
  logic       cfg_two_stop = 1'b0;
  logic [7:0] cfg_guard = 8'd0;
  logic       cmd_tx_on = 0, cmd_tx_off = 0, cmd_tx_reset = 0;
  logic       cmd_send_addr = 0, cmd_brk_start = 0, cmd_brk_stop = 0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       txd, tx_ready, tx_empty;

  int total = 0;
  int bad = 0;
  logic log_bits [0:511];
  int n_log = 0;

  sertx_guard i_sertx_guard (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_len(cfg_len), .cfg_nine(cfg_nine), .cfg_msb_first(cfg_msb_first),
    .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop), .cfg_guard(cfg_guard),
    .cmd_tx_on(cmd_tx_on), .cmd_tx_off(cmd_tx_off), .cmd_tx_reset(cmd_tx_reset),
    .cmd_send_addr(cmd_send_addr), .cmd_brk_start(cmd_brk_start),
    .cmd_brk_stop(cmd_brk_stop), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  always #5 clk = ~clk;

  // tick every 8 cycles; the line level seen in a tick cycle is the bit just ended
  initial begin
    forever begin
      repeat (7) @(negedge clk);
      if (n_log < 512) log_bits[n_log] = txd;
      n_log++;
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge baud_tick);
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic put(input logic [8:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_taken;
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic clear_log;
    @(negedge clk); n_log = 0;
  endtask

  function automatic logic at(input int i);
    return (i < n_log && i < 512) ? log_bits[i] : 1'bx;
  endfunction

  // Expected frame built from the bench's own reading of R2..R7
  task automatic check_frame(input string req, input logic [8:0] d, input logic adr,
                             input int from, output int nxt);
    int nb, n, p, ones;
    logic [15:0] exp_v, act_v;
    nb = cfg_nine ? 9 : 5 + int'(cfg_len);
    exp_v = '0; n = 0; ones = 0;
    exp_v[n] = 1'b0; n++;
    for (int i = 0; i < nb; i++) begin
      exp_v[n] = cfg_msb_first ? d[nb-1-i] : d[i];
      if (d[i]) ones++;
      n++;
    end
    if (cfg_parity != 3'd4 && cfg_parity < 3'd6) begin
      case (cfg_parity)
        3'd0: exp_v[n] = (ones % 2) == 1;
        3'd1: exp_v[n] = (ones % 2) == 0;
        3'd2: exp_v[n] = 1'b0;
        3'd3: exp_v[n] = 1'b1;
        default: exp_v[n] = adr;
      endcase
      n++;
    end
    exp_v[n] = 1'b1; n++;
    if (cfg_two_stop) begin exp_v[n] = 1'b1; n++; end
    p = from;
    while (p < n_log && at(p) !== 1'b0) p++;
    act_v = '0;
    for (int k = 0; k < n; k++) act_v[k] = at(p + k);
    check(act_v === exp_v, req, act_v, exp_v);
    nxt = p + n;
  endtask

  function automatic int ones_run(input int from);
    int c = 0;
    while (from + c < n_log && at(from + c) === 1'b1) c++;
    return c;
  endfunction

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle line, free slot, no break
    check(txd === 1'b1, "R1 line idle", txd, 1);
    check(tx_ready === 1'b1 && tx_empty === 1'b1, "R1 flags", {tx_ready, tx_empty}, 3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_basic;
    int nx;
    cfg_len = 2'd3; cfg_parity = 3'd4; cfg_guard = 0; cfg_two_stop = 0;
    pulse(cmd_tx_on);
    clear_log;
    put(9'h0A5);
    // R10: slot occupied right after the write
    check(tx_empty === 1'b0 && tx_ready === 1'b0, "R10 busy after write", {tx_ready, tx_empty}, 0);
    ticks(14);
    check_frame("R2 8N1 frame", 9'h0A5, 0, 0, nx);
    check(tx_empty === 1'b1 && tx_ready === 1'b1, "R10 free after send", {tx_ready, tx_empty}, 3);
  endtask

  task automatic t_width_order;
    int nx;
    cfg_len = 2'd0; cfg_msb_first = 0;
    clear_log; put(9'h1F3); ticks(12);
    check_frame("R3 five-bit width", 9'h1F3, 0, 0, nx);
    cfg_nine = 1; cfg_msb_first = 1;
    clear_log; put(9'h1A5); ticks(14);
    check_frame("R3 R4 nine-bit msb first", 9'h1A5, 0, 0, nx);
    cfg_nine = 0; cfg_len = 2'd3;
    clear_log; put(9'h0C2); ticks(14);
    check_frame("R4 eight-bit msb first", 9'h0C2, 0, 0, nx);
    cfg_msb_first = 0;
  endtask

  task automatic t_parity;
    int nx;
    cfg_parity = 3'd0; clear_log; put(9'h007); ticks(15);
    check_frame("R5 even", 9'h007, 0, 0, nx);
    cfg_parity = 3'd1; clear_log; put(9'h007); ticks(15);
    check_frame("R5 odd", 9'h007, 0, 0, nx);
    cfg_parity = 3'd2; clear_log; put(9'h0FF); ticks(15);
    check_frame("R5 forced zero", 9'h0FF, 0, 0, nx);
    cfg_parity = 3'd3; clear_log; put(9'h000); ticks(15);
    check_frame("R5 forced one", 9'h000, 0, 0, nx);
    cfg_parity = 3'd4;
  endtask

  task automatic t_multidrop;
    int nx, nx2;
    cfg_parity = 3'd5;
    clear_log;
    pulse(cmd_send_addr);
    put(9'h041); wait_taken; put(9'h042);
    ticks(26);
    check_frame("R6 address char", 9'h041, 1, 0, nx);
    check_frame("R6 data char", 9'h042, 0, nx, nx2);
    cfg_parity = 3'd4;
  endtask

  task automatic t_stops_guard;
    int nx, nx2;
    cfg_two_stop = 1; cfg_guard = 0;
    clear_log; put(9'h055); wait_taken; put(9'h0AA); ticks(26);
    check_frame("R7 two stops", 9'h055, 0, 0, nx);
    check(at(nx) === 1'b0, "R7 R8 back-to-back start", at(nx), 0);
    check_frame("R7 second frame", 9'h0AA, 0, nx, nx2);
    cfg_two_stop = 0; cfg_guard = 8'd3;
    ticks(2);
    clear_log; put(9'h011); wait_taken; put(9'h022); ticks(28);
    check_frame("R8 first", 9'h011, 0, 0, nx);
    check(ones_run(nx) == 3, "R8 guard gap", ones_run(nx), 3);
    check_frame("R8 second", 9'h022, 0, nx, nx2);
    cfg_guard = 0;
    ticks(4);
  endtask

  task automatic t_break;
    int nx;
    bit low;
    clear_log;
    put(9'h03C);
    pulse(cmd_brk_start);
    check(tx_ready === 1'b0, "R9 ready low on request", tx_ready, 0);
    ticks(22);
    check_frame("R9 char before break", 9'h03C, 0, 0, nx);
    low = 1;
    for (int k = 0; k < 8; k++) if (at(nx + k) !== 1'b0) low = 0;
    check(low, "R9 line held low", low, 1);
    check(tx_ready === 1'b0, "R9 ready low in break", tx_ready, 0);
    @(negedge clk); cmd_brk_stop = 1'b1;
    @(negedge clk); cmd_brk_stop = 1'b0;
    check(txd === 1'b1 && tx_ready === 1'b1, "R9 release", {txd, tx_ready}, 3);
  endtask

  task automatic t_full_ignore;
    int nx;
    pulse(cmd_tx_off);
    clear_log;
    put(9'h0E1); put(9'h01E);
    ticks(14);
    // R11: held but disabled, nothing leaves
    check(ones_run(0) >= 13, "R11 disabled hold", ones_run(0), 13);
    pulse(cmd_tx_on);
    ticks(14);
    check_frame("R10 write while full dropped", 9'h0E1, 0, 0, nx);
    check(tx_empty === 1'b1, "R10 nothing left", tx_empty, 1);
  endtask

  task automatic t_disable_mid;
    int nx, nx2;
    clear_log;
    put(9'h096); wait_taken;
    ticks(3);
    pulse(cmd_tx_off);
    ticks(10);
    check_frame("R11 in-flight completes", 9'h096, 0, 0, nx);
    put(9'h069); ticks(16);
    check(ones_run(nx) >= 14 && tx_empty === 1'b0, "R11 no start while off", ones_run(nx), 14);
    pulse(cmd_tx_on);
    ticks(14);
    check_frame("R11 resumes at boundary", 9'h069, 0, nx, nx2);
  endtask

  task automatic t_abort;
    put(9'h000); wait_taken; put(9'h0FF);
    ticks(3);
    check(txd === 1'b0, "R12 mid character", txd, 0);
    @(negedge clk); cmd_tx_reset = 1'b1;
    @(negedge clk); cmd_tx_reset = 1'b0;
    check(txd === 1'b1, "R12 line high after abort", txd, 1);
    check(tx_empty === 1'b1 && tx_ready === 1'b1, "R12 slot flushed", {tx_ready, tx_empty}, 3);
    clear_log;
    ticks(16);
    check(ones_run(0) >= 15, "R12 no further frame", ones_run(0), 15);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_basic;
    t_width_order;
    t_parity;
    t_multidrop;
    t_stops_guard;
    t_break;
    t_full_ignore;
    t_disable_mid;
    t_abort;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule